// File: doc/BRIEF.md
# Asynchronous Serial Port with Line Inversion and Break

This block is a single-channel asynchronous serial transceiver for a host bus. Software writes a byte to the data location to send it and reads the same location to collect a received byte. A second location is written as a control word and read as a status word. A third location holds a 16-bit divider that sets the bit rate. There is one holding byte on the transmit side and one received byte on the receive side, with no deeper queue.

The control word selects the parity options and the interrupt enables. It can invert the receive pin and the transmit pin independently, clears the sticky error flags, and can force the transmit line low as a break. The status word reports each receive error and a summary of them. It also shows the buffer flags, the synchronised level of the receive pin and the break state, and it echoes five of the control settings. Two level-sensitive interrupt outputs indicate that a byte is waiting or that the transmitter can take another byte.

Top module: `serial_port_pol`

## Requirements
- R1: After reset the status word reads 0x2100 (only bit 13, the idle receive level, and bit 8, transmit buffer empty, are set). The divider reads 0, the data location reads 0, `tx_out` is 1 and both interrupts are 0.
- R2: A transmitted frame is a low start bit, eight data bits LSB first, a parity bit when enabled, and one high stop bit. Each bit lasts 16×(divider+1) clocks.
- R3: Control bit 1 enables parity. With control bit 0 clear the parity bit makes the count of ones even, and with control bit 0 set it makes the count odd.
- R4: Control bit 2 inverts the transmit pin and control bit 3 inverts the receive pin before the receiver decodes it.
- R5: While control bit 14 is set, `tx_out` is 0 whatever the inversion setting, and status bit 14 reads 1.
- R6: The receiver looks for a start bit and confirms it half a bit later. It then samples each later bit one bit time apart, which places each sample mid-bit. A completed byte goes to the data location (addr 0) and sets status bit 7. A read of addr 0 clears bit 7.
- R7: If a byte completes while status bit 7 is still set, status bit 11 (overrun) is set and the previously stored byte is kept.
- R8: A low stop bit sets status bit 10 and a parity mismatch sets status bit 9. The three error bits are sticky. Status bit 15 is their OR. A control write with bit 6 set clears all three.
- R9: `irq_rx` is 1 exactly while status bit 7 and control bit 5 are both set. `irq_tx` is 1 exactly while status bit 8 and control bit 4 are both set.
- R10: Status bits 4..0 read back control bits 4..0. Status bit 13 is the receive pin level after a two-clock synchroniser and before inversion.
- R11: Status bit 8 is 1 when the holding byte is free. A data write made while it is 0 is ignored. The holding byte moves into the shifter one clock after the shifter goes idle.
- R12: Address 0 is data, address 1 is control (write) and status (read), address 2 is the divider (read and write), and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; only its effect on address 0 matters |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| rx_in | input | 1 | Serial receive pin |
| tx_out | output | 1 | Serial transmit pin |
| irq_tx | output | 1 | Transmit-ready interrupt |
| irq_rx | output | 1 | Receive-ready interrupt |

## Verification
The bench loops the transmitter back to the receiver, both with and without both inversions. A design that applied inversion on only one side, or inverted the break level, would lose frames or show a high line during break. Two frames are received without a read in between: a design that overwrote the stored byte or failed to set overrun would read back 0x22 or a clean status. Frames are also injected with a low stop bit or a wrong parity bit, so swapped error positions or a summary bit that ignores one error show up. A second data write in the same cycle that the holding byte is claimed must be dropped; a design that accepted it would send a second byte and leave the receive-full flag set.

// File: rtl/serial_port_pol.sv
module serial_port_pol #(
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        rx_in,
  output logic        tx_out,
  output logic        irq_tx,
  output logic        irq_rx
);
  localparam int CW = DIV_W + 5;
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_DIV = 2'd2;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_t;

  logic [DIV_W-1:0] div_q;
  logic odd_q, paren_q, txinv_q, rxinv_q, tie_q, rie_q, brk_q;

  wire data_wr = wr_en && addr == A_DATA;
  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire div_wr  = wr_en && addr == A_DIV;
  wire data_rd = rd_en && addr == A_DATA;

  wire [CW-1:0] bit_len  = (CW'(div_q) + CW'(1)) << 4;
  wire [CW-1:0] half_len = (CW'(div_q) + CW'(1)) << 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      {odd_q, paren_q, txinv_q, rxinv_q, tie_q, rie_q, brk_q} <= '0;
    end else begin
      if (div_wr) div_q <= wdata[DIV_W-1:0];
      if (ctrl_wr) begin
        odd_q   <= wdata[0];
        paren_q <= wdata[1];
        txinv_q <= wdata[2];
        rxinv_q <= wdata[3];
        tie_q   <= wdata[4];
        rie_q   <= wdata[5];
        brk_q   <= wdata[14];
      end
    end
  end

  // transmit side
  logic [7:0]    hold_q;
  logic          hold_v;
  logic          tx_busy;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;

  wire tx_load  = !tx_busy && hold_v;
  wire tx_par   = (^hold_q) ^ odd_q;
  wire tx_bdone = tx_cnt == bit_len - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hold_v  <= 1'b0;
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else begin
      if (tx_load) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, paren_q ? tx_par : 1'b1, hold_q, 1'b0};
        tx_left <= paren_q ? 4'd11 : 4'd10;
        tx_cnt  <= '0;
        hold_v  <= 1'b0;
      end else begin
        if (data_wr && !hold_v) begin
          hold_q <= wdata[7:0];
          hold_v <= 1'b1;
        end
        if (tx_busy) begin
          if (tx_bdone) begin
            tx_cnt  <= '0;
            tx_sh   <= {1'b1, tx_sh[10:1]};
            tx_left <= tx_left - 4'd1;
            if (tx_left == 4'd1) tx_busy <= 1'b0;
          end else begin
            tx_cnt <= tx_cnt + CW'(1);
          end
        end
      end
    end
  end

  wire tx_line = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_out = brk_q ? 1'b0 : (tx_line ^ txinv_q);

  // receive side
  logic [1:0]    rx_s;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic          rx_pbit;
  logic [7:0]    rx_data;
  logic          rbf_q, oe_q, fe_q, pe_q;

  wire rx_raw  = rx_s[1];
  wire rx_bit  = rx_raw ^ rxinv_q;
  wire rx_end  = rx_cnt == bit_len - CW'(1);
  wire rx_half = rx_cnt == half_len - CW'(1);
  wire rx_done = rx_st == RX_STOP && rx_end;
  wire perr    = paren_q && (((^rx_sh) ^ rx_pbit) != odd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s    <= 2'b11;
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_pbit <= 1'b0;
    end else begin
      rx_s <= {rx_s[0], rx_in};
      unique case (rx_st)
        RX_IDLE: if (!rx_bit) begin
          rx_st  <= RX_START;
          rx_cnt <= '0;
        end
        RX_START: if (rx_half) begin
          rx_cnt <= '0;
          rx_idx <= '0;
          rx_st  <= rx_bit ? RX_IDLE : RX_DATA;
        end else rx_cnt <= rx_cnt + CW'(1);
        RX_DATA: if (rx_end) begin
          rx_cnt <= '0;
          rx_sh  <= {rx_bit, rx_sh[7:1]};
          rx_idx <= rx_idx + 3'd1;
          if (rx_idx == 3'd7) rx_st <= paren_q ? RX_PAR : RX_STOP;
        end else rx_cnt <= rx_cnt + CW'(1);
        RX_PAR: if (rx_end) begin
          rx_cnt  <= '0;
          rx_pbit <= rx_bit;
          rx_st   <= RX_STOP;
        end else rx_cnt <= rx_cnt + CW'(1);
        RX_STOP: if (rx_end) begin
          rx_cnt <= '0;
          rx_st  <= RX_IDLE;
        end else rx_cnt <= rx_cnt + CW'(1);
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      {rbf_q, oe_q, fe_q, pe_q} <= '0;
    end else begin
      if (ctrl_wr && wdata[6]) {oe_q, fe_q, pe_q} <= '0;
      if (data_rd) rbf_q <= 1'b0;
      if (rx_done) begin
        rbf_q <= 1'b1;
        if (perr)    pe_q <= 1'b1;
        if (!rx_bit) fe_q <= 1'b1;
        if (rbf_q) oe_q <= 1'b1;
        else       rx_data <= rx_sh;
      end
    end
  end

  wire tbe = !hold_v;
  wire [15:0] status = {oe_q | fe_q | pe_q, brk_q, rx_raw, 1'b0, oe_q, fe_q, pe_q,
                        tbe, rbf_q, 2'b00, tie_q, rxinv_q, txinv_q, paren_q, odd_q};

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = {8'h00, rx_data};
      A_CTRL:  rdata = status;
      A_DIV:   rdata = 16'(div_q);
      default: rdata = 16'h0000;
    endcase
  end

  assign irq_rx = rbf_q & rie_q;
  assign irq_tx = tbe & tie_q;
endmodule

// File: rtl/serial_port_pol_chk.sv
module serial_port_pol_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_out,
  input logic       tx_busy,
  input logic       hold_v,
  input logic       tx_first,
  input logic [3:0] tx_left,
  input logic       ctrl_wr,
  input logic       brk_req,
  input logic       rx_done,
  input logic       rbf,
  input logic       oe,
  input logic       data_rd
);
  p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && brk_req) |=> !tx_out);

  p_claim_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !tx_busy) |=> (tx_busy && !hold_v));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_first);

  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_left <= 4'd11);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rbf) |=> oe);

  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rbf);

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done) |=> !rbf);
endmodule

bind serial_port_pol serial_port_pol_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .tx_busy(tx_busy), .hold_v(hold_v),
  .tx_first(tx_sh[0]), .tx_left(tx_left), .ctrl_wr(ctrl_wr), .brk_req(wdata[14]),
  .rx_done(rx_done), .rbf(rbf_q), .oe(oe_q), .data_rd(data_rd)
);

// File: tb/serial_port_pol_bench.sv
module serial_port_pol_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rx_drv = 1'b1, loop = 1'b0;
  logic rx_in, tx_out, irq_tx, irq_rx;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  assign rx_in = loop ? tx_out : rx_drv;

  serial_port_pol u_serial_port_pol (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_in(rx_in), .tx_out(tx_out),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  // behavioural reference model
  int m_div;
  bit m_odd, m_par, m_txi, m_rxi, m_tie, m_rie, m_brk;
  bit m_hv, m_busy, m_rbf, m_oe, m_fe, m_pe, m_s1, m_s2;
  bit [7:0] m_hold, m_rdata, m_rb;
  bit m_q[$];
  bit m_rp;
  int m_tc, m_rs, m_rc, m_ri;

  function automatic logic [15:0] m_status();
    return {m_oe | m_fe | m_pe, m_brk, m_s2, 1'b0, m_oe, m_fe, m_pe, !m_hv, m_rbf,
            2'b00, m_tie, m_rxi, m_txi, m_par, m_odd};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; {m_odd, m_par, m_txi, m_rxi, m_tie, m_rie, m_brk} = '0;
      m_hv = 0; m_busy = 0; m_rbf = 0; m_oe = 0; m_fe = 0; m_pe = 0;
      m_s1 = 1; m_s2 = 1; m_hold = 0; m_rdata = 0; m_rb = 0; m_rp = 0;
      m_q.delete(); m_tc = 0; m_rs = 0; m_rc = 0; m_ri = 0;
    end else begin
      int bt, hf;
      bit old_hv, old_rbf, r, done, stopv, perr;
      bt = 16 * (m_div + 1); hf = 8 * (m_div + 1);
      old_hv = m_hv; old_rbf = m_rbf; done = 0; stopv = 1;
      r = m_s2 ^ m_rxi;
      if (!m_busy && m_hv) begin
        m_q.delete(); m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
        if (m_par) m_q.push_back((^m_hold) ^ m_odd);
        m_q.push_back(1'b1);
        m_busy = 1; m_tc = 0; m_hv = 0;
      end else if (m_busy) begin
        if (m_tc == bt - 1) begin
          m_tc = 0; void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end else m_tc++;
      end
      case (m_rs)
        0: if (!r) begin m_rs = 1; m_rc = 0; end
        1: if (m_rc == hf - 1) begin m_rc = 0; m_ri = 0; m_rs = r ? 0 : 2; end else m_rc++;
        2: if (m_rc == bt - 1) begin
             m_rc = 0; m_rb[m_ri] = r; m_ri++;
             if (m_ri == 8) m_rs = m_par ? 3 : 4;
           end else m_rc++;
        3: if (m_rc == bt - 1) begin m_rc = 0; m_rp = r; m_rs = 4; end else m_rc++;
        default: if (m_rc == bt - 1) begin m_rc = 0; m_rs = 0; done = 1; stopv = r; end else m_rc++;
      endcase
      perr = m_par && (((^m_rb) ^ m_rp) != m_odd);
      if (wr_en && addr == 2'd1 && wdata[6]) begin m_oe = 0; m_fe = 0; m_pe = 0; end
      if (rd_en && addr == 2'd0) m_rbf = 0;
      if (done) begin
        m_rbf = 1;
        if (perr) m_pe = 1;
        if (!stopv) m_fe = 1;
        if (old_rbf) m_oe = 1; else m_rdata = m_rb;
      end
      if (wr_en) begin
        case (addr)
          2'd0: if (!old_hv && !(!m_busy && old_hv)) begin m_hold = wdata[7:0]; m_hv = 1; end
          2'd1: {m_brk, m_rie, m_tie, m_rxi, m_txi, m_par, m_odd} =
                  {wdata[14], wdata[5], wdata[4], wdata[3], wdata[2], wdata[1], wdata[0]};
          2'd2: m_div = int'(wdata);
          default: ;
        endcase
      end
      m_s2 = m_s1; m_s1 = rx_in;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic exp_tx;
      logic [15:0] exp_rd;
      exp_tx = m_brk ? 1'b0 : ((m_busy ? m_q[0] : 1'b1) ^ m_txi);
      case (addr)
        2'd0: exp_rd = {8'h00, m_rdata};
        2'd1: exp_rd = m_status();
        2'd2: exp_rd = 16'(m_div);
        default: exp_rd = 16'h0000;
      endcase
      check("R2 R3 R4 R5 tx_out", tx_out, exp_tx);
      check("R9 irq_rx", irq_rx, m_rbf & m_rie);
      check("R9 irq_tx", irq_tx, !m_hv & m_tie);
      check("R12 R8 R10 rdata", rdata, exp_rd);
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1; wdata = '0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [15:0] exp, string tag);
    addr = a; rd_en = (a == 2'd0);
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0; addr = 2'd1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(logic [7:0] d, bit with_par, bit pval, bit stopv, int bt);
    rx_drv = 1'b0; idle(bt);
    for (int i = 0; i < 8; i++) begin rx_drv = d[i]; idle(bt); end
    if (with_par) begin rx_drv = pval; idle(bt); end
    rx_drv = stopv; idle(bt);
    rx_drv = 1'b1; idle(2 * bt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state, R12 map
    rd_chk(2'd1, 16'h2100, "R1 status after reset");
    rd_chk(2'd2, 16'h0000, "R1 divider after reset");
    rd_chk(2'd0, 16'h0000, "R1 data after reset");
    rd_chk(2'd3, 16'h0000, "R12 unused address");
    check("R1 tx idle high", tx_out, 1);
    check("R1 irq_tx low", irq_tx, 0);

    // R9 tx interrupt, R10 echo
    wr(2'd1, 16'h0010);
    check("R9 irq_tx with empty buffer", irq_tx, 1);
    wr(2'd1, 16'h0017);
    rd_chk(2'd1, 16'h2117, "R10 control echo");

    // R2 R3 R6 even parity loopback
    loop = 1'b1;
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'h00A5);
    idle(220);
    rd_chk(2'd1, 16'h2182, "R6 receive full after even frame");
    wr(2'd1, 16'h0022);
    check("R9 irq_rx with full buffer", irq_rx, 1);
    rd_chk(2'd0, 16'h00A5, "R3 even parity byte");
    check("R6 irq_rx drops after read", irq_rx, 0);

    // R3 odd parity
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h003C);
    idle(220);
    rd_chk(2'd0, 16'h003C, "R3 odd parity byte");
    rd_chk(2'd1, 16'h2103, "R3 no parity error with odd parity");

    // R2 divider 1, no parity
    wr(2'd2, 16'h0001);
    rd_chk(2'd2, 16'h0001, "R12 divider readback");
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0081);
    idle(400);
    rd_chk(2'd0, 16'h0081, "R2 slower bit time byte");
    wr(2'd2, 16'h0000);

    // R4 inversion both sides
    wr(2'd1, 16'h000C);
    idle(20);
    check("R4 inverted idle line", tx_out, 0);
    rd_chk(2'd1, 16'h010C, "R10 raw input low with inversion");
    wr(2'd0, 16'h005A);
    idle(220);
    rd_chk(2'd0, 16'h005A, "R4 inverted loopback byte");
    wr(2'd1, 16'h0000);
    idle(20);

    // R5 break
    loop = 1'b0;
    wr(2'd1, 16'h4004);
    check("R5 break low with inversion", tx_out, 0);
    rd_chk(2'd1, 16'h6104, "R5 break status");
    wr(2'd1, 16'h0000);
    check("R5 line released", tx_out, 1);

    // R7 overrun and R8 clear
    loop = 1'b1;
    wr(2'd0, 16'h0011);
    idle(220);
    wr(2'd0, 16'h0022);
    idle(220);
    rd_chk(2'd1, 16'hA980, "R7 overrun status");
    rd_chk(2'd0, 16'h0011, "R7 first byte kept");
    wr(2'd1, 16'h0040);
    rd_chk(2'd1, 16'h2100, "R8 errors cleared");

    // R8 framing error
    loop = 1'b0;
    idle(10);
    send_rx(8'h55, 0, 0, 0, 16);
    idle(40);
    rd_chk(2'd1, 16'hA580, "R8 framing error status");
    rd_chk(2'd0, 16'h0055, "R8 byte with bad stop");
    wr(2'd1, 16'h0040);

    // R8 parity error
    wr(2'd1, 16'h0002);
    idle(10);
    send_rx(8'h07, 1, 0, 1, 16);
    rd_chk(2'd1, 16'hA382, "R8 parity error status");
    rd_chk(2'd0, 16'h0007, "R8 byte with bad parity");
    wr(2'd1, 16'h0040);
    rd_chk(2'd1, 16'h2100, "R8 parity error cleared");

    // R11 write while holding byte is claimed
    loop = 1'b1;
    wr(2'd0, 16'h0012);
    wr(2'd0, 16'h0034);
    idle(220);
    rd_chk(2'd0, 16'h0012, "R11 first byte sent");
    idle(250);
    rd_chk(2'd1, 16'h2100, "R11 second write dropped");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule